// File: doc/BRIEF.md
# Machine-Check and Debug-Entry Controller

This controller sits next to a processor core and chooses the response to a machine-check event. The response depends on three settings: the machine-state check enable, a debug-mode strap, and two per-cause debug enable bits. There are three possible responses:

- enter the terminal check-stop state;
- vector to the machine-check interrupt, which also requests the save/restore registers;
- enter debug mode.

Each response loads a 32-bit exception cause register (ECR) with a single-bit code.

In debug mode the controller changes how exceptions are handled. An exception only rewrites the ECR and pulses a report line toward the development port. The save/restore registers are never requested and the core stays in debug mode. Fetches granted in debug mode are flagged for redirection to the development port. The fetch that follows a reported exception is held back for one cycle, so the report always comes before it. Load/store traffic is not steered by this block.

All interfaces are plain strobes and levels, with no back-pressure. A strobe is acted on in the cycle in which it is sampled high.

Top module: `mck_dbg_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `mode_o` is 2'b00 (run), `ecr_o` is zero, and every action, report and save pulse is low.
- R2: With `dbg_en_i` low, a machine check in run mode does one of two things. With `msr_mce_i` low it enters check-stop (`mode_o`=2'b10) and loads ECR with 0x2000_0000. With `msr_mce_i` high it takes the interrupt and loads ECR with 0x1000_0000.
- R3: With `dbg_en_i` high and `msr_mce_i` low, `der_chstp_en_i` picks the machine-check response: 0 enters check-stop and 1 enters debug mode (`mode_o`=2'b01). ECR becomes 0x2000_0000 in both cases.
- R4: With `dbg_en_i` high and `msr_mce_i` high, `der_mci_en_i` picks the machine-check response: 0 takes the interrupt and 1 enters debug mode. ECR becomes 0x1000_0000 in both cases.
- R5: The action outputs `act_chkstop_o`, `act_mci_o` and `act_dbg_o` are one-cycle pulses in the cycle after the machine check, and at most one of them is high. `srr_save_o` pulses with `act_mci_o`.
- R6: In debug mode, a generic exception with code c (0..31) writes ECR = 1<<c. A machine check instead writes the cause value selected by `msr_mce_i`. Either one raises `exc_report_o` for exactly the following cycle, keeps `mode_o` at debug, pulses no action, and never raises `srr_save_o`.
- R7: `fetch_grant_o` follows `fetch_req_i` in run and debug mode, except that it is low in the cycle in which `exc_report_o` is high.
- R8: `fetch_redirect_o` is high exactly when a fetch is granted in debug mode.
- R9: Check-stop is left only by reset. In that state, machine checks, exceptions and return strobes have no effect: ECR is frozen, no pulse is issued and no fetch is granted.
- R10: `dbg_ret_i` returns debug mode to run mode. It is ignored in a cycle that also carries an exception or machine check, and it is ignored in run mode.
- R11: When a machine check and a generic exception arrive in the same cycle, the ECR takes the machine-check value.
- R12: In run mode, a generic exception pulses `srr_save_o` for one cycle and leaves ECR and `exc_report_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msr_mce_i | input | 1 | Machine-check enable from machine state |
| dbg_en_i | input | 1 | Debug-mode enable strap |
| der_chstp_en_i | input | 1 | Debug enable: check-stop cause goes to debug |
| der_mci_en_i | input | 1 | Debug enable: machine-check interrupt goes to debug |
| mchk_i | input | 1 | Machine-check event strobe |
| exc_i | input | 1 | Generic exception strobe |
| exc_code_i | input | 5 | Generic exception cause code |
| dbg_ret_i | input | 1 | Return-from-debug strobe |
| fetch_req_i | input | 1 | Core fetch request |
| mode_o | output | 2 | 00 run, 01 debug, 10 check-stop |
| act_chkstop_o | output | 1 | Pulse: check-stop entered |
| act_mci_o | output | 1 | Pulse: machine-check interrupt taken |
| act_dbg_o | output | 1 | Pulse: debug mode entered |
| srr_save_o | output | 1 | Pulse: save/restore registers to be written |
| ecr_o | output | 32 | Exception cause register |
| exc_report_o | output | 1 | One-cycle in-debug exception report |
| fetch_grant_o | output | 1 | Fetch may issue this cycle |
| fetch_redirect_o | output | 1 | Granted fetch goes to the development port |

## Verification
All sixteen combinations of the machine-check enable, the strap and the two debug enable bits are swept from reset. This sweep separates the check-stop, interrupt and debug-entry outcomes, and shows that each enable bit matters only in its own half of the table. In debug mode all 32 cause codes are applied one at a time, which shows the one-hot ECR position, the single report pulse and the held fetch for every code. Simultaneous machine check and exception, a return colliding with an exception, run-mode exceptions, and strobes sent into check-stop cover the priority and ignore rules.

// File: rtl/mck_dbg_pkg.sv
package mck_dbg_pkg;

  typedef enum logic [1:0] {
    MODE_RUN = 2'b00,
    MODE_DBG = 2'b01,
    MODE_CHK = 2'b10
  } mode_e;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_CHK  = 2'd1,
    ACT_MCI  = 2'd2,
    ACT_DBG  = 2'd3
  } act_e;

endpackage

// File: rtl/mck_action_decode.sv
module mck_action_decode
  import mck_dbg_pkg::*;
#(
  parameter int ECR_W   = 32,
  parameter int MCI_BIT = 28,
  parameter int CHK_BIT = 29
) (
  input  logic             mce_i,
  input  logic             dbg_en_i,
  input  logic             chstp_en_i,
  input  logic             mci_en_i,
  output act_e             act_o,
  output logic [ECR_W-1:0] cause_o
);

  localparam logic [ECR_W-1:0] ONE = {{(ECR_W-1){1'b0}}, 1'b1};

  always_comb begin
    if (!dbg_en_i) begin
      act_o = mce_i ? ACT_MCI : ACT_CHK;
    end else if (!mce_i) begin
      act_o = chstp_en_i ? ACT_DBG : ACT_CHK;
    end else begin
      act_o = mci_en_i ? ACT_DBG : ACT_MCI;
    end
  end

  assign cause_o = mce_i ? (ONE << MCI_BIT) : (ONE << CHK_BIT);

endmodule

// File: rtl/mck_mode_fsm.sv
module mck_mode_fsm
  import mck_dbg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  mchk_i,
  input  logic  exc_i,
  input  logic  ret_i,
  input  act_e  act_i,
  output mode_e mode_o,
  output logic  act_chk_o,
  output logic  act_mci_o,
  output logic  act_dbg_o,
  output logic  srr_save_o
);

  mode_e mode_q, mode_d;
  logic  chk_d, mci_d, dbg_d, srr_d;

  always_comb begin
    mode_d = mode_q;
    chk_d  = 1'b0;
    mci_d  = 1'b0;
    dbg_d  = 1'b0;
    srr_d  = 1'b0;
    unique case (mode_q)
      MODE_RUN: begin
        if (mchk_i) begin
          unique case (act_i)
            ACT_CHK: begin mode_d = MODE_CHK; chk_d = 1'b1; end
            ACT_MCI: begin mci_d = 1'b1; srr_d = 1'b1; end
            ACT_DBG: begin mode_d = MODE_DBG; dbg_d = 1'b1; end
            default: ;
          endcase
        end else if (exc_i) begin
          srr_d = 1'b1;
        end
      end
      MODE_DBG: begin
        if (!(mchk_i || exc_i) && ret_i) mode_d = MODE_RUN;
      end
      default: mode_d = MODE_CHK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= MODE_RUN;
      act_chk_o  <= 1'b0;
      act_mci_o  <= 1'b0;
      act_dbg_o  <= 1'b0;
      srr_save_o <= 1'b0;
    end else begin
      mode_q     <= mode_d;
      act_chk_o  <= chk_d;
      act_mci_o  <= mci_d;
      act_dbg_o  <= dbg_d;
      srr_save_o <= srr_d;
    end
  end

  assign mode_o = mode_q;

  AST_ACT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({act_chk_o, act_mci_o, act_dbg_o})) else $error("AST_ACT_EXCLUSIVE"); // R5
  AST_CHK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_CHK) |=> (mode_q == MODE_CHK)) else $error("AST_CHK_STICKY"); // R9
  AST_NO_SRR_IN_DBG: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_DBG) |=> !srr_save_o) else $error("AST_NO_SRR_IN_DBG"); // R6
  AST_MCI_SAVES: assert property (@(posedge clk) disable iff (!rst_n)
    act_mci_o |-> srr_save_o) else $error("AST_MCI_SAVES"); // R5

endmodule

// File: rtl/mck_cause_unit.sv
module mck_cause_unit
  import mck_dbg_pkg::*;
#(
  parameter int ECR_W  = 32,
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mode_e             mode_i,
  input  logic              mchk_i,
  input  logic              exc_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [ECR_W-1:0]  mc_cause_i,
  output logic [ECR_W-1:0]  ecr_o,
  output logic              report_o
);

  localparam logic [ECR_W-1:0] ONE = {{(ECR_W-1){1'b0}}, 1'b1};

  logic in_dbg, live;
  assign in_dbg = (mode_i == MODE_DBG);
  assign live   = (mode_i != MODE_CHK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ecr_o    <= '0;
      report_o <= 1'b0;
    end else begin
      if (live && mchk_i) begin
        ecr_o <= mc_cause_i;
      end else if (in_dbg && exc_i) begin
        ecr_o <= ONE << code_i;
      end
      report_o <= in_dbg && (mchk_i || exc_i);
    end
  end

  AST_ECR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_CHK) |=> $stable(ecr_o)) else $error("AST_ECR_FROZEN"); // R9

endmodule

// File: rtl/mck_dbg_ctrl.sv
module mck_dbg_ctrl
  import mck_dbg_pkg::*;
#(
  parameter int ECR_W   = 32,
  parameter int MCI_BIT = 28,
  parameter int CHK_BIT = 29,
  localparam int CODE_W = $clog2(ECR_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msr_mce_i,
  input  logic              dbg_en_i,
  input  logic              der_chstp_en_i,
  input  logic              der_mci_en_i,
  input  logic              mchk_i,
  input  logic              exc_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              dbg_ret_i,
  input  logic              fetch_req_i,
  output logic [1:0]        mode_o,
  output logic              act_chkstop_o,
  output logic              act_mci_o,
  output logic              act_dbg_o,
  output logic              srr_save_o,
  output logic [ECR_W-1:0]  ecr_o,
  output logic              exc_report_o,
  output logic              fetch_grant_o,
  output logic              fetch_redirect_o
);

  act_e             act;
  logic [ECR_W-1:0] mc_cause;
  mode_e            mode;

  mck_action_decode #(.ECR_W(ECR_W), .MCI_BIT(MCI_BIT), .CHK_BIT(CHK_BIT)) u_dec (
    .mce_i      (msr_mce_i),
    .dbg_en_i   (dbg_en_i),
    .chstp_en_i (der_chstp_en_i),
    .mci_en_i   (der_mci_en_i),
    .act_o      (act),
    .cause_o    (mc_cause)
  );

  mck_mode_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .mchk_i     (mchk_i),
    .exc_i      (exc_i),
    .ret_i      (dbg_ret_i),
    .act_i      (act),
    .mode_o     (mode),
    .act_chk_o  (act_chkstop_o),
    .act_mci_o  (act_mci_o),
    .act_dbg_o  (act_dbg_o),
    .srr_save_o (srr_save_o)
  );

  mck_cause_unit #(.ECR_W(ECR_W), .CODE_W(CODE_W)) u_cause (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode),
    .mchk_i     (mchk_i),
    .exc_i      (exc_i),
    .code_i     (exc_code_i),
    .mc_cause_i (mc_cause),
    .ecr_o      (ecr_o),
    .report_o   (exc_report_o)
  );

  assign mode_o           = mode;
  assign fetch_grant_o    = fetch_req_i && (mode != MODE_CHK) && !exc_report_o;
  assign fetch_redirect_o = fetch_grant_o && (mode == MODE_DBG);

  AST_DBG_EXC_REPORTS: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MODE_DBG) && (mchk_i || exc_i)) |=> (exc_report_o && (mode == MODE_DBG)))
    else $error("AST_DBG_EXC_REPORTS"); // R6
  AST_FETCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MODE_DBG) && (mchk_i || exc_i)) |=> !fetch_grant_o)
    else $error("AST_FETCH_HELD"); // R7
  AST_MC_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode != MODE_CHK) && mchk_i) |=> (ecr_o == $past(mc_cause)))
    else $error("AST_MC_PRIORITY"); // R11

endmodule

// File: tb/mck_dbg_ctrl_tb_top.sv
module mck_dbg_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mce = 0, dbg_en = 0, chstp = 0, mcie = 0;
  logic        mchk = 0, exc = 0, ret = 0, freq = 0;
  logic [4:0]  code = '0;
  logic [1:0]  mode;
  logic        a_chk, a_mci, a_dbg, srr, rep, grant, redir;
  logic [31:0] ecr;

  int vectors = 0;
  int errors  = 0;

  always #10 clk = ~clk;

  mck_dbg_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .msr_mce_i(mce), .dbg_en_i(dbg_en),
    .der_chstp_en_i(chstp), .der_mci_en_i(mcie), .mchk_i(mchk), .exc_i(exc),
    .exc_code_i(code), .dbg_ret_i(ret), .fetch_req_i(freq), .mode_o(mode),
    .act_chkstop_o(a_chk), .act_mci_o(a_mci), .act_dbg_o(a_dbg),
    .srr_save_o(srr), .ecr_o(ecr), .exc_report_o(rep),
    .fetch_grant_o(grant), .fetch_redirect_o(redir)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    mchk = 0; exc = 0; ret = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // drive strobes for one edge, sample at the following negedge, clear strobes
  task automatic strobe(input logic m, input logic e, input logic [4:0] c, input logic r);
    mchk = m; exc = e; code = c; ret = r;
    @(negedge clk);
    mchk = 0; exc = 0; ret = 0;
  endtask

  function automatic logic [2:0] exp_act(input logic mc, input logic de,
                                         input logic cs, input logic mi);
    // {chk, mci, dbg}
    if (!de) return mc ? 3'b010 : 3'b100;
    if (!mc) return cs ? 3'b001 : 3'b100;
    return mi ? 3'b001 : 3'b010;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [2:0] ea;
    logic [1:0] em;
    logic [31:0] ec;

    do_reset();
    check("R1 mode", {30'd0, mode}, 32'd0);
    check("R1 ecr", ecr, 32'd0);
    check("R1 pulses", {28'd0, a_chk, a_mci, a_dbg, rep}, 32'd0);
    check("R1 srr", {31'd0, srr}, 32'd0);

    // R2 R3 R4 R5: full sweep of the configuration bits
    for (int k = 0; k < 16; k++) begin
      do_reset();
      {mce, dbg_en, chstp, mcie} = k[3:0];
      freq = 1'b1;
      strobe(1, 0, 5'd0, 0);
      ea = exp_act(mce, dbg_en, chstp, mcie);
      em = ea[2] ? 2'b10 : (ea[0] ? 2'b01 : 2'b00);
      ec = mce ? 32'h1000_0000 : 32'h2000_0000;
      check(dbg_en ? (mce ? "R4 action" : "R3 action") : "R2 action",
            {29'd0, a_chk, a_mci, a_dbg}, {29'd0, ea});
      check("R2 R3 R4 mode", {30'd0, mode}, {30'd0, em});
      check("R2 R3 R4 ecr", ecr, ec);
      check("R5 srr with mci", {31'd0, srr}, {31'd0, ea[1]});
      @(negedge clk);
      check("R5 pulse width", {28'd0, a_chk, a_mci, a_dbg, srr}, 32'd0);
    end

    // enter debug via check-stop cause
    do_reset();
    mce = 0; dbg_en = 1; chstp = 1; mcie = 0; freq = 1;
    strobe(1, 0, 5'd0, 0);
    check("R3 enter dbg", {30'd0, mode}, 32'd1);
    check("R8 redirect idle", {30'd0, grant, redir}, 32'd3);

    for (int c = 0; c < 32; c++) begin
      strobe(0, 1, c[4:0], 0);
      check("R6 ecr code", ecr, 32'd1 << c);
      check("R6 report", {31'd0, rep}, 32'd1);
      check("R6 mode", {30'd0, mode}, 32'd1);
      check("R6 no srr/act", {28'd0, srr, a_chk, a_mci, a_dbg}, 32'd0);
      check("R7 fetch held", {30'd0, grant, redir}, 32'd0);
      @(negedge clk);
      check("R6 report one cycle", {31'd0, rep}, 32'd0);
      check("R7 R8 fetch resumes", {30'd0, grant, redir}, 32'd3);
    end

    // R11 in debug: machine check beats exception
    mce = 1;
    strobe(1, 1, 5'd3, 0);
    check("R11 dbg ecr", ecr, 32'h1000_0000);
    check("R6 mc report", {31'd0, rep}, 32'd1);
    check("R6 mc no act", {29'd0, a_chk, a_mci, a_dbg}, 32'd0);
    check("R6 mc mode", {30'd0, mode}, 32'd1);
    @(negedge clk);

    // R10 return collides with exception
    strobe(0, 1, 5'd7, 1);
    check("R10 collide stays dbg", {30'd0, mode}, 32'd1);
    check("R10 collide ecr", ecr, 32'h0000_0080);
    @(negedge clk);
    strobe(0, 0, 5'd0, 1);
    check("R10 return", {30'd0, mode}, 32'd0);
    check("R8 no redirect in run", {30'd0, grant, redir}, 32'd2);
    strobe(0, 0, 5'd0, 1);
    check("R10 ret in run", {30'd0, mode}, 32'd0);

    // R12 run-mode exception
    strobe(0, 1, 5'd4, 0);
    check("R12 srr", {31'd0, srr}, 32'd1);
    check("R12 ecr kept", ecr, 32'h0000_0080);
    check("R12 no report", {31'd0, rep}, 32'd0);
    @(negedge clk);
    check("R12 srr one cycle", {31'd0, srr}, 32'd0);

    // R11 in run, then R9 check-stop
    mce = 0; dbg_en = 0;
    strobe(1, 1, 5'd1, 0);
    check("R11 run ecr", ecr, 32'h2000_0000);
    check("R2 chkstop", {30'd0, mode}, 32'd2);
    check("R9 no grant", {31'd0, grant}, 32'd0);
    @(negedge clk);
    mce = 1; dbg_en = 1; mcie = 1;
    strobe(1, 0, 5'd0, 0);
    check("R9 mc ignored", {29'd0, a_chk, a_mci, a_dbg}, 32'd0);
    strobe(0, 1, 5'd9, 1);
    check("R9 ecr frozen", ecr, 32'h2000_0000);
    check("R9 mode", {30'd0, mode}, 32'd2);
    check("R9 quiet", {29'd0, srr, rep, grant}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule